// File: doc/BRIEF.md
# Outer-Bank Program/Pattern Address Mapper

This block is the address-mapping logic of a cartridge for an 8-bit console. The CPU programs it by writing to the upper half of its address space. Each such write shifts one data bit into a five-bit loader. The fifth write moves the assembled value into one of four internal registers: control, pattern bank A, pattern bank B and program bank. From these registers, the current CPU address and the current PPU address, the block drives the upper program ROM address bits, address bit 12 of the 8 KB pattern RAM, the nametable RAM select line and the program RAM chip enable.

The program ROM holds 512 KB and is split into two 256 KB halves. The usual program-bank register selects only 16 KB or 32 KB pieces inside the current half. The half itself comes from bit 4 of a pattern bank register. This works because the pattern memory is RAM and needs only one bank bit. Every fixed-bank mode pins the first or last 16 KB of the *current* half, not of the whole ROM. In 4 KB pattern mode, PPU address bit 12 chooses which pattern register supplies the half-select bit. The program ROM half can therefore change while the picture is being drawn.

Top module: `outer_bank_mapper`

## Requirements
- R1: After reset the control register holds 5'b01100: single-screen nametable 0, $C000-$FFFF fixed to the last inner bank, 8 KB pattern mode. All other registers hold zero.
- R2: A write with CPU A15=1 and data bit 7 clear shifts data bit 0 in, least significant bit first. The fifth such write loads the five-bit value into the register chosen by A14:A13 (00 control, 01 pattern A, 10 pattern B, 11 program). Fewer than five writes change no register.
- R3: A write with A15=1 and data bit 7 set empties the loader and sets control bits 3:2 to 11. Control bits 4 and 1:0 stay unchanged.
- R4: When control bits 3:2 are 0x (32 KB mode), the inner bank number is {program[3:1], CPU A14}.
- R5: When control bits 3:2 are 10, CPU $8000-$BFFF reads inner bank 0 and $C000-$FFFF reads program[3:0].
- R6: When control bits 3:2 are 11, $8000-$BFFF reads program[3:0] and $C000-$FFFF reads inner bank 15.
- R7: When control bit 4 is 0 (8 KB pattern mode), the output prg_addr_hi[4] (ROM A18) equals pattern A bit 4, whatever pattern B holds and whatever PPU A12 is.
- R8: When control bit 4 is 1 (4 KB pattern mode), ROM A18 equals pattern A bit 4 while PPU A12 is 0 and pattern B bit 4 while PPU A12 is 1.
- R9: Pattern RAM A12 follows PPU A12 in 8 KB mode. In 4 KB mode it is pattern A bit 0 when PPU A12=0 and pattern B bit 0 when PPU A12=1.
- R10: The nametable select is 0 when control bits 1:0 are 00, 1 when they are 01, PPU A10 when they are 10 and PPU A11 when they are 11.
- R11: The program RAM enable is high only for CPU addresses $6000-$7FFF, and only while program bit 4 is 0.
- R12: Writes with CPU A15=0 neither shift the loader nor change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| ppu_a12 | input | 1 | PPU address bit 12 |
| prg_addr_hi | output | 5 | Program ROM A18 (bit 4) and inner 16 KB bank A17:A14 |
| chr_a12 | output | 1 | Pattern RAM address bit 12 |
| nt_a10 | output | 1 | Nametable RAM select |
| prg_ram_ce | output | 1 | Program RAM enable |

## Verification
The bench puts a set half-select bit under each fixed-bank mode. A design that fixed the last bank of the whole ROM instead of the current half would then drive the wrong A18. Pattern B is given a different half-select bit, and PPU A12 is toggled in both pattern modes. This shows up a design that reads pattern B in 8 KB mode, or one that never switches halves in 4 KB mode. A reset write is placed after a partial load, and that write is followed by a full load. A loader that kept stale bits would then assemble the wrong bank. Non-mapper writes are slipped into the middle of a load, which catches a loader that counts every CPU write.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
   localparam int REG_W = 5;

   // register indices selected by CPU A14:A13
   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_PATA = 2'd1;
   localparam logic [1:0] SEL_PATB = 2'd2;
   localparam logic [1:0] SEL_PROG = 2'd3;

   // control field positions
   localparam int CTRL_NT_LO   = 0;
   localparam int CTRL_MODE_LO = 2;
   localparam int CTRL_PAT4K   = 4;
   // bit 4 of pattern registers: outer program half
   localparam int PAT_HALF     = 4;
   // bit 4 of program register: RAM disable
   localparam int PROG_RAM_OFF = 4;

   typedef enum logic [1:0] {
      PM_WIDE0  = 2'b00,
      PM_WIDE1  = 2'b01,
      PM_FIRST  = 2'b10,
      PM_LAST   = 2'b11
   } prg_mode_e;

   typedef enum logic [1:0] {
      NT_ONE_LO = 2'b00,
      NT_ONE_HI = 2'b01,
      NT_VERT   = 2'b10,
      NT_HORZ   = 2'b11
   } nt_mode_e;

   localparam logic [REG_W-1:0] CTRL_RESET = 5'b01100;
   localparam logic [REG_W-1:0] MODE_FORCE = 5'b01100;

   typedef logic [3:0][REG_W-1:0] reg_bank_t;
endpackage

// File: rtl/mapper_serial_loader.sv
module mapper_serial_loader
   import mapper_pkg::*;
#(
   parameter int LOAD_LEN = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_stb,
   input  logic                din,
   input  logic                clr,
   output logic                commit,
   output logic [LOAD_LEN-1:0] value
);
   localparam int CW = (LOAD_LEN > 1) ? $clog2(LOAD_LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(LOAD_LEN - 1);

   logic [LOAD_LEN-2:0] sr_q;
   logic [CW-1:0]       cnt_q;

   assign commit = wr_stb && !clr && (cnt_q == LAST);
   assign value  = {din, sr_q};

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (commit) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (wr_stb) begin
         if (LOAD_LEN > 2) sr_q <= {din, sr_q[LOAD_LEN-2:1]};
         else              sr_q <= din;
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mapper_regs.sv
module mapper_regs
   import mapper_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [1:0]       sel,
   input  logic [REG_W-1:0] value,
   input  logic             clr,
   output reg_bank_t        regs_q
);
   for (genvar i = 0; i < 4; i++) begin : g_reg
      localparam logic [REG_W-1:0] RV = (i == 0) ? CTRL_RESET : '0;
      if (i == 0) begin : g_ctrl
         always_ff @(posedge clk) begin
            if (!rst_n)                         regs_q[i] <= RV;
            else if (clr)                       regs_q[i] <= regs_q[i] | MODE_FORCE;
            else if (commit && sel == 2'(i))    regs_q[i] <= value;
         end
      end else begin : g_data
         always_ff @(posedge clk) begin
            if (!rst_n)                         regs_q[i] <= RV;
            else if (commit && sel == 2'(i))    regs_q[i] <= value;
         end
      end
   end
endmodule

// File: rtl/mapper_prg_compose.sv
module mapper_prg_compose
   import mapper_pkg::*;
#(
   parameter int INNER_W = 4
) (
   input  logic             cpu_a14,
   input  logic             ppu_a12,
   input  logic [REG_W-1:0] ctrl,
   input  logic [REG_W-1:0] pat_a,
   input  logic [REG_W-1:0] pat_b,
   input  logic [REG_W-1:0] prog,
   output logic [INNER_W:0] prg_hi
);
   logic               half;
   logic [INNER_W-1:0] inner;
   prg_mode_e          mode;

   assign mode = prg_mode_e'(ctrl[CTRL_MODE_LO +: 2]);

   always_comb begin
      if (ctrl[CTRL_PAT4K]) half = ppu_a12 ? pat_b[PAT_HALF] : pat_a[PAT_HALF];
      else                  half = pat_a[PAT_HALF];
   end

   always_comb begin
      unique case (mode)
         PM_FIRST: inner = cpu_a14 ? prog[INNER_W-1:0] : '0;
         PM_LAST:  inner = cpu_a14 ? '1 : prog[INNER_W-1:0];
         default:  inner = {prog[INNER_W-1:1], cpu_a14};
      endcase
   end

   assign prg_hi = {half, inner};
endmodule

// File: rtl/mapper_ppu_compose.sv
module mapper_ppu_compose
   import mapper_pkg::*;
(
   input  logic             ppu_a10,
   input  logic             ppu_a11,
   input  logic             ppu_a12,
   input  logic [REG_W-1:0] ctrl,
   input  logic [REG_W-1:0] pat_a,
   input  logic [REG_W-1:0] pat_b,
   output logic             chr_a12,
   output logic             nt_a10
);
   nt_mode_e nt;
   assign nt = nt_mode_e'(ctrl[CTRL_NT_LO +: 2]);

   always_comb begin
      if (ctrl[CTRL_PAT4K]) chr_a12 = ppu_a12 ? pat_b[0] : pat_a[0];
      else                  chr_a12 = ppu_a12;
   end

   always_comb begin
      unique case (nt)
         NT_ONE_LO: nt_a10 = 1'b0;
         NT_ONE_HI: nt_a10 = 1'b1;
         NT_VERT:   nt_a10 = ppu_a10;
         default:   nt_a10 = ppu_a11;
      endcase
   end
endmodule

// File: rtl/outer_bank_mapper.sv
module outer_bank_mapper
   import mapper_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int LOAD_LEN = 5,
   parameter int INNER_W  = 4,
   parameter bit RAM_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr_en,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              ppu_a10,
   input  logic              ppu_a11,
   input  logic              ppu_a12,
   output logic [INNER_W:0]  prg_addr_hi,
   output logic              chr_a12,
   output logic              nt_a10,
   output logic              prg_ram_ce
);
   localparam int TOP = ADDR_W - 1;

   if (LOAD_LEN != REG_W) begin : g_bad_len
      $error("LOAD_LEN must equal register width");
   end
   if (INNER_W < 2 || INNER_W > 4) begin : g_bad_inner
      $error("INNER_W must be 2..4");
   end
   if (ADDR_W < 15 || DATA_W < 8) begin : g_bad_bus
      $error("bus too narrow");
   end

   logic                map_wr, clr, commit;
   logic [REG_W-1:0]    value;
   reg_bank_t           regs_q;
   logic [REG_W-1:0]    ctrl_q, pata_q, patb_q, prog_q;
   logic                ram_win;

   assign map_wr = cpu_wr_en && cpu_addr[TOP];
   assign clr    = map_wr && cpu_data[7];

   mapper_serial_loader #(.LOAD_LEN(LOAD_LEN)) u_load (
      .clk(clk), .rst_n(rst_n), .wr_stb(map_wr), .din(cpu_data[0]),
      .clr(clr), .commit(commit), .value(value)
   );

   mapper_regs u_regs (
      .clk(clk), .rst_n(rst_n), .commit(commit), .sel(cpu_addr[TOP-1:TOP-2]),
      .value(value), .clr(clr), .regs_q(regs_q)
   );

   assign ctrl_q = regs_q[SEL_CTRL];
   assign pata_q = regs_q[SEL_PATA];
   assign patb_q = regs_q[SEL_PATB];
   assign prog_q = regs_q[SEL_PROG];

   mapper_prg_compose #(.INNER_W(INNER_W)) u_prg (
      .cpu_a14(cpu_addr[TOP-1]), .ppu_a12(ppu_a12), .ctrl(ctrl_q),
      .pat_a(pata_q), .pat_b(patb_q), .prog(prog_q), .prg_hi(prg_addr_hi)
   );

   mapper_ppu_compose u_ppu (
      .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .ppu_a12(ppu_a12), .ctrl(ctrl_q),
      .pat_a(pata_q), .pat_b(patb_q), .chr_a12(chr_a12), .nt_a10(nt_a10)
   );

   assign ram_win = (cpu_addr[TOP:TOP-2] == 3'b011);

   if (RAM_GATE) begin : g_ram_gated
      assign prg_ram_ce = ram_win && !prog_q[PROG_RAM_OFF];
   end else begin : g_ram_open
      assign prg_ram_ce = ram_win;
   end
endmodule

// File: rtl/outer_bank_mapper_chk.sv
module outer_bank_mapper_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cpu_wr_en,
   input logic [15:0] cpu_addr,
   input logic [7:0]  cpu_data,
   input logic        ppu_a12,
   input logic [4:0]  prg_addr_hi,
   input logic        prg_ram_ce,
   input logic [4:0]  ctrl_q,
   input logic [4:0]  pata_q,
   input logic [4:0]  patb_q,
   input logic [4:0]  prog_q
);
   assert_reset_ctrl_R1: assert property (@(posedge clk)
      !rst_n |=> ctrl_q == 5'b01100);

   assert_soft_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr_en && cpu_addr[15] && cpu_data[7])
      |=> (ctrl_q[3:2] == 2'b11 && $stable(ctrl_q[1:0]) && $stable(ctrl_q[4])));

   assert_first_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[3:2] == 2'b10 && !cpu_addr[14]) |-> prg_addr_hi[3:0] == 4'd0);

   assert_last_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[3:2] == 2'b11 && cpu_addr[14]) |-> prg_addr_hi[3:0] == 4'hF);

   assert_half_8k_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[4] |-> prg_addr_hi[4] == pata_q[4]);

   assert_half_4k_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[4] && ppu_a12) |-> prg_addr_hi[4] == patb_q[4]);

   assert_ram_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
      prg_ram_ce |-> (cpu_addr[15:13] == 3'b011 && !prog_q[4]));

   assert_low_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr_en && !cpu_addr[15])
      |=> ($stable(ctrl_q) && $stable(pata_q) && $stable(patb_q) && $stable(prog_q)));
endmodule

bind outer_bank_mapper outer_bank_mapper_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
   .cpu_data(cpu_data), .ppu_a12(ppu_a12), .prg_addr_hi(prg_addr_hi),
   .prg_ram_ce(prg_ram_ce), .ctrl_q(ctrl_q), .pata_q(pata_q),
   .patb_q(patb_q), .prog_q(prog_q)
);

// File: tb/outer_bank_mapper_test.sv
`timescale 1ns/1ps
module outer_bank_mapper_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr_en = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_data = 8'h00;
   logic        ppu_a10 = 1'b0, ppu_a11 = 1'b0, ppu_a12 = 1'b0;
   logic [4:0]  prg_addr_hi;
   logic        chr_a12, nt_a10, prg_ram_ce;

   always #2.5 clk = ~clk;

   outer_bank_mapper uut (
      .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
      .cpu_data(cpu_data), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .ppu_a12(ppu_a12),
      .prg_addr_hi(prg_addr_hi), .chr_a12(chr_a12), .nt_a10(nt_a10),
      .prg_ram_ce(prg_ram_ce)
   );

   typedef struct {
      string      req;
      logic [4:0] prg;
      logic       chr;
      logic       nt;
      logic       ce;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;

   // bench model of register contents
   logic [4:0] m_ctrl = 5'b01100, m_pa = 5'd0, m_pb = 5'd0, m_pr = 5'd0;

   function automatic logic [4:0] f_prg(logic a14, logic a12);
      logic half;
      logic [3:0] inner;
      half = m_ctrl[4] ? (a12 ? m_pb[4] : m_pa[4]) : m_pa[4];
      case (m_ctrl[3:2])
         2'b10:   inner = a14 ? m_pr[3:0] : 4'd0;
         2'b11:   inner = a14 ? 4'hF : m_pr[3:0];
         default: inner = {m_pr[3:1], a14};
      endcase
      return {half, inner};
   endfunction

   function automatic logic f_nt(logic a10, logic a11);
      case (m_ctrl[1:0])
         2'b00:   return 1'b0;
         2'b01:   return 1'b1;
         2'b10:   return a10;
         default: return a11;
      endcase
   endfunction

   task automatic probe(string req, logic [15:0] a, logic a10, logic a11, logic a12);
      exp_t e;
      @(negedge clk);
      cpu_addr = a; ppu_a10 = a10; ppu_a11 = a11; ppu_a12 = a12;
      e.req = req;
      e.prg = f_prg(a[14], a12);
      e.chr = m_ctrl[4] ? (a12 ? m_pb[0] : m_pa[0]) : a12;
      e.nt  = f_nt(a10, a11);
      e.ce  = (a[15:13] == 3'b011) && !m_pr[4];
      q.push_back(e);
   endtask

   task automatic raw_wr(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      cpu_wr_en = 1'b1; cpu_addr = a; cpu_data = d;
      @(negedge clk);
      cpu_wr_en = 1'b0;
   endtask

   task automatic load(logic [15:0] a, logic [4:0] v);
      for (int i = 0; i < 5; i++) raw_wr(a, {7'd0, v[i]});
      case (a[14:13])
         2'd0: m_ctrl = v;
         2'd1: m_pa = v;
         2'd2: m_pb = v;
         default: m_pr = v;
      endcase
   endtask

   task automatic soft_reset();
      raw_wr(16'h8000, 8'h80);
      m_ctrl = m_ctrl | 5'b01100;
   endtask

   // monitor: compares outputs away from the clock edge
   always @(negedge clk) begin
      #1;
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (prg_addr_hi !== e.prg || chr_a12 !== e.chr || nt_a10 !== e.nt || prg_ram_ce !== e.ce) begin
            failures++;
            $display("FAIL %s: got prg=%h chr=%b nt=%b ce=%b expected prg=%h chr=%b nt=%b ce=%b",
                     e.req, prg_addr_hi, chr_a12, nt_a10, prg_ram_ce, e.prg, e.chr, e.nt, e.ce);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state: fixed-last mode, nametable 0, RAM enabled
      probe("R1", 16'hC000, 1'b1, 1'b1, 1'b0);
      probe("R1", 16'h8000, 1'b0, 1'b0, 1'b1);
      probe("R1", 16'h6000, 1'b0, 1'b0, 1'b0);

      // R2 full load of program register, R6 last-fixed mode
      load(16'hE000, 5'b00110);
      probe("R2", 16'h8000, 1'b0, 1'b0, 1'b0);
      probe("R6", 16'hC000, 1'b0, 1'b0, 1'b0);

      // R2 partial load leaves registers unchanged
      raw_wr(16'hE000, 8'h01); raw_wr(16'hE000, 8'h01); raw_wr(16'hE000, 8'h01);
      probe("R2", 16'h8000, 1'b0, 1'b0, 1'b0);

      // R3 soft reset clears partial load; following full load is clean
      soft_reset();
      load(16'hE000, 5'b01001);
      probe("R3", 16'h8000, 1'b0, 1'b0, 1'b0);

      // R3 soft reset keeps mirroring bits
      load(16'h8000, 5'b00011);
      soft_reset();
      probe("R3", 16'hC000, 1'b0, 1'b1, 1'b0);
      probe("R3", 16'h8000, 1'b1, 1'b0, 1'b0);

      // R4 32 KB mode
      load(16'h8000, 5'b00000);
      probe("R4", 16'h8000, 1'b0, 1'b0, 1'b0);
      probe("R4", 16'hC000, 1'b0, 1'b0, 1'b0);

      // outer half set via pattern A; pattern B differs
      load(16'hA000, 5'b10001);
      load(16'hC000, 5'b00000);
      // R5 first-fixed mode in upper half
      load(16'h8000, 5'b01000);
      probe("R5", 16'h8000, 1'b0, 1'b0, 1'b0);
      probe("R5", 16'hC000, 1'b0, 1'b0, 1'b1);
      // R6 last-fixed in upper half
      load(16'h8000, 5'b01100);
      probe("R6", 16'hC000, 1'b0, 1'b0, 1'b1);
      probe("R6", 16'h8000, 1'b0, 1'b0, 1'b0);

      // R7 / R9 8 KB mode: pattern B ignored, chr follows A12
      probe("R7", 16'h9000, 1'b0, 1'b0, 1'b1);
      probe("R9", 16'h9000, 1'b0, 1'b0, 1'b0);

      // R8 / R9 4 KB mode: A12 chooses the register
      load(16'h8000, 5'b11100);
      probe("R8", 16'hC000, 1'b0, 1'b0, 1'b0);
      probe("R8", 16'hC000, 1'b0, 1'b0, 1'b1);
      load(16'hC000, 5'b10000);
      load(16'hA000, 5'b00001);
      probe("R8", 16'h8000, 1'b0, 1'b0, 1'b1);
      probe("R9", 16'h8000, 1'b0, 1'b0, 1'b0);

      // R10 nametable modes
      for (int m = 0; m < 4; m++) begin
         load(16'h8000, {3'b011, 2'(m)});
         probe("R10", 16'h8000, 1'b1, 1'b0, 1'b0);
         probe("R10", 16'h8000, 1'b0, 1'b1, 1'b0);
      end

      // R11 RAM disable and out-of-window
      probe("R11", 16'h7FFF, 1'b0, 1'b0, 1'b0);
      probe("R11", 16'hA000, 1'b0, 1'b0, 1'b0);
      load(16'hE000, 5'b10010);
      probe("R11", 16'h6000, 1'b0, 1'b0, 1'b0);

      // R12 low writes interleaved with a program-register load
      raw_wr(16'hE000, 8'h00);
      raw_wr(16'hE000, 8'h01);
      raw_wr(16'h6000, 8'h01);
      raw_wr(16'h7000, 8'h00);
      probe("R12", 16'h6000, 1'b0, 1'b0, 1'b0);
      raw_wr(16'hE000, 8'h01);
      raw_wr(16'hE000, 8'h00);
      raw_wr(16'hE000, 8'h00);
      m_pr = 5'b00110;
      probe("R12", 16'h8000, 1'b0, 1'b0, 1'b0);
      probe("R12", 16'h6000, 1'b0, 1'b0, 1'b0);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule